// File: doc/BRIEF.md
# Offset Block Byte Interleaver

This block spreads each group of four 240-byte frames across a 4 x 240 byte matrix so that burst errors in the channel are scattered over several frames. Each frame becomes one row of the matrix. The first byte of a row is not stored in column 0. Instead, every row starts 60 columns further along than the row above it, and the position wraps around the end of the row. Once all four rows are filled, the matrix is read out column by column, taking the four rows of one column before moving on to the next column.

The block holds two matrices. While one group is being written into one of them, the previous group is read out of the other. A stream of bytes with a frame sync goes in, and the block produces a stream of bytes with a group sync one group later. The writer waits for the first frame sync after reset before it accepts anything. From then on it counts bytes on its own, so later frame syncs only confirm the frame boundaries it has already counted.

Top module: `ilv_offset_interleaver`

## Requirements
- R1: While reset is held, and in the first cycles after it, `out_valid` and `out_gsync` are low.
- R2: Bytes that arrive with `in_valid` high before the first `in_sof` after reset are discarded. The byte that carries that first `in_sof` becomes byte 0 of frame 0 of the first group.
- R3: Byte k (0 to 239) of frame r (0 to 3) within a group is stored at row r, column (k + 60*r) mod 240.
- R4: A group is read out as 960 bytes. Column c holds output positions 4c to 4c+3, and those positions carry rows 0, 1, 2 and 3 of column c, in that order.
- R5: When the last byte of a group is accepted at clock edge E, the first output byte of that group appears at edge E+1 with `out_gsync` high. `out_gsync` is high only on that first byte.
- R6: Once a group's output has started, `out_valid` stays high for exactly 960 consecutive cycles. At all other times it is low.
- R7: A cycle in which `in_valid` is low neither advances nor disturbs the write position.
- R8: A group that completes at the same edge as the previous group's final read begins its output in the very next cycle. The two groups then form an unbroken stream, because writing and reading always use different matrices.
- R9: An `in_sof` that arrives after the first one has no effect. In particular, one that lands in the middle of a frame does not realign the write position.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all logic acts on the rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_data | input | DATA_W | Input byte |
| in_valid | input | 1 | Marks `in_data` as a byte to accept |
| in_sof | input | 1 | Frame sync, high together with the first byte of a frame |
| out_data | output | DATA_W | Interleaved output byte |
| out_valid | output | 1 | Marks `out_data` as an interleaved byte |
| out_gsync | output | 1 | High with the first output byte of each group |

## Verification
Two operations can coincide in one cycle. The last byte of a new group can be written, swapping the banks, while the final byte of the previous group is still being read. This is provoked by sending two groups back to back at full rate, so the second completes exactly 960 edges after the first. The reference model is judged on every cycle. `out_valid` must stay high across the seam, `out_gsync` must rise on the byte right after the 960th, and every byte of the second group must come from the freshly filled bank. A third group is sent with idle gaps and a stray mid-frame sync, to show that neither shifts the write position.

// File: rtl/ilv_pkg.sv
package ilv_pkg;

  // Adds two values that are both below the modulus and folds the sum back into range.
  function automatic int unsigned wrap_add(int unsigned a, int unsigned b, int unsigned m);
    int unsigned s;
    s = a + b;
    return (s >= m) ? s - m : s;
  endfunction

  // Turns a row and column into a linear cell index inside one matrix.
  function automatic int unsigned cell_index(int unsigned row, int unsigned col,
                                             int unsigned frame_len);
    return row * frame_len + col;
  endfunction

  // Returns the offset of a bank within the shared memory.
  function automatic int unsigned bank_base(logic bank, int unsigned group);
    return bank ? group : 0;
  endfunction

endpackage

// File: rtl/ilv_wr_ctrl.sv
module ilv_wr_ctrl #(
  parameter int FRAME_LEN = 240,
  parameter int DEPTH     = 4,
  parameter int SHIFT     = 60
) (
  input  logic                                    clk,
  input  logic                                    rst_n,
  input  logic                                    in_valid,
  input  logic                                    in_sof,
  output logic                                    wr_en,
  output logic [$clog2(2*FRAME_LEN*DEPTH)-1:0]    wr_addr,
  output logic                                    wr_bank,
  output logic                                    group_done
);
  localparam int GROUP = FRAME_LEN * DEPTH;
  localparam int AW    = $clog2(2 * GROUP);
  localparam int KW    = $clog2(FRAME_LEN);
  localparam int RW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic          locked_q;
  logic          bank_q;
  logic [KW-1:0] cnt_q;
  logic [KW-1:0] col_q;
  logic [KW-1:0] start_q;
  logic [RW-1:0] row_q;
  logic [KW-1:0] next_start;
  logic [KW-1:0] next_col;
  logic          frame_end;
  logic          row_end;

  assign frame_end  = (cnt_q == KW'(FRAME_LEN - 1));
  assign row_end    = (row_q == RW'(DEPTH - 1));
  assign next_start = KW'(ilv_pkg::wrap_add(32'(start_q), SHIFT, FRAME_LEN));
  assign next_col   = KW'(ilv_pkg::wrap_add(32'(col_q), 1, FRAME_LEN));

  assign wr_en      = in_valid && (locked_q || in_sof);
  assign group_done = wr_en && frame_end && row_end;
  assign wr_bank    = bank_q;
  assign wr_addr    = AW'(ilv_pkg::cell_index(32'(row_q), 32'(col_q), FRAME_LEN)
                        + ilv_pkg::bank_base(bank_q, GROUP));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked_q <= 1'b0;
      bank_q   <= 1'b0;
      cnt_q    <= '0;
      col_q    <= '0;
      start_q  <= '0;
      row_q    <= '0;
    end else if (wr_en) begin
      locked_q <= 1'b1;
      if (frame_end) begin
        cnt_q <= '0;
        if (row_end) begin
          row_q   <= '0;
          start_q <= '0;
          col_q   <= '0;
          bank_q  <= ~bank_q;
        end else begin
          row_q   <= row_q + 1'b1;
          start_q <= next_start;
          col_q   <= next_start;
        end
      end else begin
        cnt_q <= cnt_q + 1'b1;
        col_q <= next_col;
      end
    end
  end
endmodule

// File: rtl/ilv_rd_ctrl.sv
module ilv_rd_ctrl #(
  parameter int FRAME_LEN = 240,
  parameter int DEPTH     = 4
) (
  input  logic                                    clk,
  input  logic                                    rst_n,
  input  logic                                    start,
  input  logic                                    start_bank,
  output logic                                    rd_en,
  output logic [$clog2(2*FRAME_LEN*DEPTH)-1:0]    rd_addr,
  output logic                                    rd_bank,
  output logic                                    rd_first
);
  localparam int GROUP = FRAME_LEN * DEPTH;
  localparam int AW    = $clog2(2 * GROUP);
  localparam int KW    = $clog2(FRAME_LEN);
  localparam int RW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic          active_q;
  logic          bank_q;
  logic [KW-1:0] col_q;
  logic [RW-1:0] row_q;
  logic          row_end;
  logic          col_end;

  assign row_end  = (row_q == RW'(DEPTH - 1));
  assign col_end  = (col_q == KW'(FRAME_LEN - 1));
  assign rd_en    = active_q;
  assign rd_bank  = bank_q;
  assign rd_first = active_q && (col_q == '0) && (row_q == '0);
  assign rd_addr  = AW'(ilv_pkg::cell_index(32'(row_q), 32'(col_q), FRAME_LEN)
                        + ilv_pkg::bank_base(bank_q, GROUP));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      bank_q   <= 1'b0;
      col_q    <= '0;
      row_q    <= '0;
    end else if (start) begin
      active_q <= 1'b1;
      bank_q   <= start_bank;
      col_q    <= '0;
      row_q    <= '0;
    end else if (active_q) begin
      if (row_end) begin
        row_q <= '0;
        if (col_end) begin
          active_q <= 1'b0;
        end else begin
          col_q <= col_q + 1'b1;
        end
      end else begin
        row_q <= row_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/ilv_bank_ram.sv
module ilv_bank_ram #(
  parameter int DATA_W = 8,
  parameter int WORDS  = 1920,
  parameter int AW     = 11
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
    if (re) begin
      rdata <= mem[raddr];
    end
  end
endmodule

// File: rtl/ilv_offset_interleaver.sv
module ilv_offset_interleaver #(
  parameter int DATA_W    = 8,
  parameter int FRAME_LEN = 240,
  parameter int DEPTH     = 4,
  parameter int SHIFT     = 60
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_valid,
  input  logic              in_sof,
  output logic [DATA_W-1:0] out_data,
  output logic              out_valid,
  output logic              out_gsync
);
  localparam int GROUP = FRAME_LEN * DEPTH;
  localparam int WORDS = 2 * GROUP;
  localparam int AW    = $clog2(WORDS);

  // Named events, visible to the bound checker.
  logic          wr_en;
  logic [AW-1:0] wr_addr;
  logic          wr_bank;
  logic          group_done;
  logic          rd_en;
  logic [AW-1:0] rd_addr;
  logic          rd_bank;
  logic          rd_first;
  logic          valid_q;
  logic          gsync_q;

  ilv_wr_ctrl #(.FRAME_LEN(FRAME_LEN), .DEPTH(DEPTH), .SHIFT(SHIFT)) u_wr (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_sof     (in_sof),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_bank    (wr_bank),
    .group_done (group_done)
  );

  ilv_rd_ctrl #(.FRAME_LEN(FRAME_LEN), .DEPTH(DEPTH)) u_rd (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (group_done),
    .start_bank (wr_bank),
    .rd_en      (rd_en),
    .rd_addr    (rd_addr),
    .rd_bank    (rd_bank),
    .rd_first   (rd_first)
  );

  ilv_bank_ram #(.DATA_W(DATA_W), .WORDS(WORDS), .AW(AW)) u_ram (
    .clk   (clk),
    .we    (wr_en),
    .waddr (wr_addr),
    .wdata (in_data),
    .re    (rd_en),
    .raddr (rd_addr),
    .rdata (out_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      gsync_q <= 1'b0;
    end else begin
      valid_q <= rd_en;
      gsync_q <= rd_first;
    end
  end

  assign out_valid = valid_q;
  assign out_gsync = gsync_q;
endmodule

// File: rtl/ilv_offset_interleaver_chk.sv
module ilv_offset_interleaver_chk #(
  parameter int GROUP = 960,
  parameter int AW    = 11
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr,
  input logic          wr_bank,
  input logic          group_done,
  input logic          rd_en,
  input logic          rd_bank,
  input logic          out_valid,
  input logic          out_gsync
);
  localparam int PW = $clog2(GROUP + 2);

  // Output bytes seen since the last group sync; the window is tracked here, not by a delay.
  logic [PW-1:0] pos_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= '0;
    end else if (out_valid) begin
      pos_q <= out_gsync ? PW'(1) : pos_q + 1'b1;
    end
  end

  assert_addr_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (32'(wr_addr) < 2 * GROUP));

  assert_burst_length_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_gsync) |-> (pos_q != '0 && pos_q < PW'(GROUP)));

  assert_sync_boundary_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_gsync |-> (out_valid && (pos_q == '0 || pos_q == PW'(GROUP))));

  assert_sync_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
    group_done |-> ##2 (out_valid && out_gsync));

  assert_burst_unbroken_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pos_q != '0 && pos_q < PW'(GROUP)) |-> out_valid);

  assert_bank_split_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && rd_en) |-> (wr_bank != rd_bank));
endmodule

bind ilv_offset_interleaver ilv_offset_interleaver_chk #(.GROUP(GROUP), .AW(AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_en      (wr_en),
  .wr_addr    (wr_addr),
  .wr_bank    (wr_bank),
  .group_done (group_done),
  .rd_en      (rd_en),
  .rd_bank    (rd_bank),
  .out_valid  (out_valid),
  .out_gsync  (out_gsync)
);

// File: tb/test_ilv_offset_interleaver.sv
`timescale 1ns/1ps
module test_ilv_offset_interleaver;
  localparam int FL  = 240;
  localparam int DP  = 4;
  localparam int SH  = 60;
  localparam int GRP = FL * DP;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] in_data = '0;
  logic       in_valid = 1'b0;
  logic       in_sof = 1'b0;
  logic [7:0] out_data;
  logic       out_valid;
  logic       out_gsync;

  typedef struct {
    int cyc;
    int data;
    bit first;
  } exp_t;

  exp_t expq[$];
  int   cyc = 0;
  int   checks = 0;
  int   fails = 0;
  int   gsync_seen = 0;
  int   valid_seen = 0;
  bit   finished = 1'b0;

  bit   m_lock = 1'b0;
  int   m_k = 0;
  int   m_r = 0;
  int   grpbuf [DP][FL];

  always #2.5 clk = ~clk;

  ilv_offset_interleaver i_ilv_offset_interleaver (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_data   (in_data),
    .in_valid  (in_valid),
    .in_sof    (in_sof),
    .out_data  (out_data),
    .out_valid (out_valid),
    .out_gsync (out_gsync)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // Output position p = 4*c + r carries row r, column c; row r column c holds frame r byte k
  // where (k + 60*r) mod 240 == c (R3, R4). The first byte lands one edge after completion (R5).
  task automatic emit(input int done_cyc);
    int idx = 0;
    for (int c = 0; c < FL; c++) begin
      for (int r = 0; r < DP; r++) begin
        int k = (c - SH * r + FL * DP) % FL;
        expq.push_back('{done_cyc + 1 + idx, grpbuf[r][k], idx == 0});
        idx++;
      end
    end
  endtask

  // Behavioural model of acceptance: locks on the first sync (R2), ignores later syncs (R9),
  // and skips cycles without valid (R7).
  always @(posedge clk) begin
    cyc++;
    if (rst_n && in_valid && (m_lock || in_sof)) begin
      m_lock = 1'b1;
      grpbuf[m_r][m_k] = int'(in_data);
      if (m_k == FL - 1) begin
        m_k = 0;
        if (m_r == DP - 1) begin
          m_r = 0;
          emit(cyc);
        end else begin
          m_r++;
        end
      end else begin
        m_k++;
      end
    end
  end

  // Compare on every cycle, sampled away from the active edge.
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (expq.size() > 0 && expq[0].cyc == cyc) begin
        chk(out_valid === 1'b1, "R6 R8 valid during group", int'(out_valid), 1);
        chk(out_gsync === expq[0].first, "R5 group sync position", int'(out_gsync),
            int'(expq[0].first));
        chk(out_data === 8'(expq[0].data), "R3 R4 interleaved byte", int'(out_data),
            expq[0].data);
        void'(expq.pop_front());
      end else begin
        chk(out_valid === 1'b0, "R6 valid outside group", int'(out_valid), 0);
        chk(out_gsync === 1'b0, "R5 sync outside group", int'(out_gsync), 0);
      end
      if (out_valid === 1'b1) valid_seen++;
      if (out_gsync === 1'b1) gsync_seen++;
    end
  end

  task automatic send(input logic [7:0] d, input bit sof, input bit v);
    in_data  = d;
    in_sof   = sof;
    in_valid = v;
    @(negedge clk);
  endtask

  // Bytes carry their own frame index and byte index; optional idle gaps (R7)
  // and an optional stray sync at byte position spur (R9).
  task automatic send_group(input int g, input bit gaps, input int spur);
    for (int b = 0; b < GRP; b++) begin
      int r = b / FL;
      int k = b % FL;
      if (gaps && (b % 7 == 3)) send(8'h55, 1'b0, 1'b0);
      send(8'((k + 37 * r + 11 * g) & 255), (k == 0) || (b == spur), 1'b1);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(out_valid === 1'b0 && out_gsync === 1'b0, "R1 outputs low in reset",
        int'(out_valid) + int'(out_gsync), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid === 1'b0, "R1 valid low after reset", int'(out_valid), 0);
    // R2: bytes before the first sync must not be taken.
    for (int i = 0; i < 5; i++) send(8'(8'hA0 + i), 1'b0, 1'b1);
    send(8'h00, 1'b0, 1'b0);
    // R8: two groups back to back at full rate.
    send_group(0, 1'b0, -1);
    send_group(1, 1'b0, -1);
    // R7, R9: gaps and a stray mid-frame sync.
    send_group(2, 1'b1, 300);
    in_valid = 1'b0;
    in_sof   = 1'b0;
    repeat (1100) @(negedge clk);
    chk(expq.size() == 0, "R4 all expected bytes produced", expq.size(), 0);
    chk(gsync_seen == 3, "R5 one sync per group", gsync_seen, 3);
    chk(valid_seen == 3 * GRP, "R6 byte count", valid_seen, 3 * GRP);
    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #250000;
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule